// File: doc/BRIEF.md
# Banked Internal Data RAM with Hardware Stack

This block holds the 128-byte on-chip data memory of a small 8-bit core. It accepts one operation per clock. Four kinds of operation address the same storage. A register access picks one of four eight-byte banks with a two-bit bank number and a byte inside that bank with a three-bit register number. A direct access takes a full byte address. A bit access takes a bit address that selects one bit of the sixteen bytes starting at 20H. Push and pop go through an internal stack pointer. That pointer starts at 07H after reset, so the first pushed byte lands at 08H, which is the first byte of bank 1.

Direct and bit addresses at 80H or above belong to the special-function register space. Those registers live outside this block. For such an address the block only drives a combinational request port, and it flags whether the addressed register supports bit access. Read results from internal memory come back one clock after the request, on a registered data port with a valid strobe. A stack operation whose target byte would fall at or above 80H is refused and reported.

Top module: `iram_bank_stack`

## Requirements
- R1: After reset the stack pointer is 07H, every memory byte reads 00H, and rvalid_o, stack_err_o and sfr_sel_o are low.
- R2: Operation code op_i = 1 (register access) addresses byte bank_i×8 + reg_i. The byte is written with wdata_i when we_i = 1 and read otherwise. The same byte is reachable by a direct access at that address.
- R3: Operation code 2 (direct access) with addr_i below 80H writes or reads that byte. Read data appears on rdata_o with rvalid_o high in the clock after the request. No valid strobe follows a write.
- R4: A direct or bit access whose byte address is 80H or above leaves internal memory untouched and gives no rvalid_o. In the same cycle it drives sfr_sel_o high, sfr_addr_o with the byte address, sfr_we_o with we_i and sfr_wdata_o with wdata_i.
- R5: sfr_bitable_o is high exactly when sfr_sel_o is high and bits [2:0] of sfr_addr_o are zero, that is, when the low nibble is 0H or 8H.
- R6: Operation code 3 (bit access) with a bit address a below 80H targets bit a[2:0] of byte 20H + (a >> 3). A bit read returns that bit on rbit_o, with rdata_o at 00H, in the following clock.
- R7: A bit write (we_i = 1) sets the target bit to wbit_i and leaves the other seven bits of the byte unchanged. An access in the very next clock already sees the new value.
- R8: A bit access at bit address 80H or above drives sfr_addr_o = a & F8H, sfr_bit_idx_o = a[2:0], sfr_wbit_o = wbit_i and sfr_bitop_o high.
- R9: Operation code 4 (push) first adds one to the stack pointer, modulo 256, and then writes wdata_i to the byte it now points at. The first push after reset writes 08H.
- R10: Operation code 5 (pop) returns the byte at the stack pointer on rdata_o with rvalid_o in the next clock, and subtracts one from the pointer, modulo 256.
- R11: If the target byte of a push (pointer + 1) or of a pop (pointer) is at or above 80H, the operation is refused. stack_err_o pulses in the next clock, and neither the pointer nor any memory byte changes.
- R12: Operation codes 0, 6 and 7 do nothing. They give no rvalid_o and no stack_err_o, leave the pointer alone, and write no memory byte, even with we_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 none, 1 register, 2 direct, 3 bit, 4 push, 5 pop |
| we_i | input | 1 | Write select for register, direct and bit accesses |
| bank_i | input | 2 | Bank number for register accesses |
| reg_i | input | 3 | Register number inside the bank |
| addr_i | input | 8 | Direct byte address or bit address |
| wdata_i | input | 8 | Write data for byte writes and pushes |
| wbit_i | input | 1 | Write value for bit writes |
| rdata_o | output | 8 | Registered byte read result |
| rbit_o | output | 1 | Registered bit read result |
| rvalid_o | output | 1 | Read result valid, one clock after the request |
| sp_o | output | 8 | Current stack pointer |
| stack_err_o | output | 1 | Refused push or pop, one clock after the request |
| sfr_sel_o | output | 1 | Access targets special-function register space |
| sfr_we_o | output | 1 | Write to the special-function register |
| sfr_addr_o | output | 8 | Special-function register byte address |
| sfr_wdata_o | output | 8 | Byte write data to the register |
| sfr_bitop_o | output | 1 | Access is a single-bit access |
| sfr_bit_idx_o | output | 3 | Bit position for a bit access |
| sfr_wbit_o | output | 1 | Bit write value |
| sfr_bitable_o | output | 1 | Addressed register supports bit access |

## Verification
The hardest states to reach are the two edges of stack overflow. One is the push refused at pointer 7FH. The other is the wrap past the bottom, where a pop at 00H leaves the pointer at FFH; after that the next pop is refused, while a push is accepted and lands at 00H. The stimulus gets there by running 120 pushes of distinct values from the reset pointer up to 7FH and then popping all 128 bytes back down. Every popped value is compared in order, and the last pops cross the register banks. Only after that are the refused pop and the accepted wrap push applied.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_REG  = 3'd1,
    OP_DIR  = 3'd2,
    OP_BIT  = 3'd3,
    OP_PUSH = 3'd4,
    OP_POP  = 3'd5
  } op_e;
endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int BANK_W = 2,
  parameter int REG_W = 3,
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  logic [2:0]        op_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [AW-1:0]     sp_i,
  output logic [AW-1:0]     tgt_o,
  output logic              is_bit_o,
  output logic              is_stack_o,
  output logic              hit_int_o,
  output logic              hit_sfr_o,
  output logic              stack_err_o
);
  localparam int BIT_IDX_W = $clog2(DW);

  logic valid;

  always_comb begin
    tgt_o      = '0;
    is_bit_o   = 1'b0;
    is_stack_o = 1'b0;
    valid      = 1'b1;
    case (op_i)
      OP_REG:  tgt_o = AW'({bank_i, reg_i});
      OP_DIR:  tgt_o = addr_i;
      OP_BIT: begin
        is_bit_o = 1'b1;
        // upper half: SFR byte holding the bit; lower half: bit window
        tgt_o = addr_i[AW-1] ? (addr_i & ~AW'(DW-1))
                             : BIT_BASE + (addr_i >> BIT_IDX_W);
      end
      OP_PUSH: begin
        is_stack_o = 1'b1;
        tgt_o      = sp_i + AW'(1);
      end
      OP_POP: begin
        is_stack_o = 1'b1;
        tgt_o      = sp_i;
      end
      default: valid = 1'b0;
    endcase
  end

  assign hit_int_o   = valid && !tgt_o[AW-1];
  assign hit_sfr_o   = valid && !is_stack_o && tgt_o[AW-1];
  assign stack_err_o = is_stack_o && tgt_o[AW-1];
endmodule

// File: rtl/iram_stack_ptr.sv
module iram_stack_ptr #(
  parameter int AW = 8,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_ok_i,
  input  logic          pop_ok_i,
  output logic [AW-1:0] sp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sp_o <= SP_RST;
    else if (push_ok_i) sp_o <= sp_o + AW'(1);
    else if (pop_ok_i)  sp_o <= sp_o - AW'(1);
  end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int DW = 8,
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BIT_IDX_W = $clog2(DW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 byte_we_i,
  input  logic                 bit_we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [BIT_IDX_W-1:0] bit_idx_i,
  input  logic                 wbit_i,
  output logic [DW-1:0]        rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (byte_we_i) begin
      mem_q[idx_i] <= wdata_i;
    end else if (bit_we_i) begin
      mem_q[idx_i][bit_idx_i] <= wbit_i;  // single-cycle read-modify-write
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/iram_bank_stack.sv
module iram_bank_stack
  import iram_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int DEPTH = 128,
  parameter int BANK_W = 2,
  parameter int REG_W = 3,
  parameter logic [AW-1:0] BIT_BASE = 8'h20,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [2:0]                op_i,
  input  logic                      we_i,
  input  logic [BANK_W-1:0]         bank_i,
  input  logic [REG_W-1:0]          reg_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      wbit_i,
  output logic [DW-1:0]             rdata_o,
  output logic                      rbit_o,
  output logic                      rvalid_o,
  output logic [AW-1:0]             sp_o,
  output logic                      stack_err_o,
  output logic                      sfr_sel_o,
  output logic                      sfr_we_o,
  output logic [AW-1:0]             sfr_addr_o,
  output logic [DW-1:0]             sfr_wdata_o,
  output logic                      sfr_bitop_o,
  output logic [$clog2(DW)-1:0]     sfr_bit_idx_o,
  output logic                      sfr_wbit_o,
  output logic                      sfr_bitable_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int BIT_IDX_W = $clog2(DW);

  logic [AW-1:0]        tgt;
  logic                 is_bit, is_stack, hit_int, hit_sfr, stk_err;
  logic                 is_word, byte_we, bit_we, rd_en, push_ok, pop_ok;
  logic [DW-1:0]        mem_rd;
  logic [BIT_IDX_W-1:0] bit_idx;

  iram_addr_map #(
    .AW(AW), .DW(DW), .BANK_W(BANK_W), .REG_W(REG_W), .BIT_BASE(BIT_BASE)
  ) u_map (
    .op_i(op_i), .bank_i(bank_i), .reg_i(reg_i), .addr_i(addr_i), .sp_i(sp_o),
    .tgt_o(tgt), .is_bit_o(is_bit), .is_stack_o(is_stack),
    .hit_int_o(hit_int), .hit_sfr_o(hit_sfr), .stack_err_o(stk_err)
  );

  assign bit_idx = addr_i[BIT_IDX_W-1:0];
  assign is_word = (op_i == OP_REG) || (op_i == OP_DIR);
  assign push_ok = (op_i == OP_PUSH) && !stk_err;
  assign pop_ok  = (op_i == OP_POP) && !stk_err;
  assign byte_we = hit_int && ((is_word && we_i) || push_ok);
  assign bit_we  = hit_int && is_bit && we_i;
  assign rd_en   = hit_int && (((is_word || is_bit) && !we_i) || pop_ok);

  iram_stack_ptr #(.AW(AW), .SP_RST(SP_RST)) u_sp (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_ok_i(push_ok), .pop_ok_i(pop_ok),
    .sp_o(sp_o)
  );

  iram_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_we_i(byte_we), .bit_we_i(bit_we),
    .idx_i(tgt[IDX_W-1:0]), .wdata_i(wdata_i), .bit_idx_i(bit_idx),
    .wbit_i(wbit_i), .rdata_o(mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o    <= 1'b0;
      rdata_o     <= '0;
      rbit_o      <= 1'b0;
      stack_err_o <= 1'b0;
    end else begin
      rvalid_o    <= rd_en;
      rdata_o     <= (rd_en && !is_bit) ? mem_rd : '0;
      rbit_o      <= rd_en && is_bit && mem_rd[bit_idx];
      stack_err_o <= stk_err;
    end
  end

  assign sfr_sel_o     = hit_sfr;
  assign sfr_we_o      = hit_sfr && we_i;
  assign sfr_addr_o    = hit_sfr ? tgt : '0;
  assign sfr_wdata_o   = hit_sfr ? wdata_i : '0;
  assign sfr_bitop_o   = hit_sfr && is_bit;
  assign sfr_bit_idx_o = (hit_sfr && is_bit) ? bit_idx : '0;
  assign sfr_wbit_o    = hit_sfr && is_bit && wbit_i;
  assign sfr_bitable_o = hit_sfr && (tgt[BIT_IDX_W-1:0] == '0);
endmodule

// File: rtl/iram_bank_stack_chk.sv
module iram_bank_stack_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] op_i,
  input logic       we_i,
  input logic [7:0] addr_i,
  input logic       rvalid_o,
  input logic       stack_err_o,
  input logic [7:0] sp_o,
  input logic       sfr_sel_o,
  input logic [7:0] sfr_addr_o,
  input logic       sfr_bitop_o,
  input logic       sfr_bitable_o
);
  logic [7:0] sp_nx;
  assign sp_nx = sp_o + 8'd1;

  assert_read_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($past(op_i) == 3'd5 || ($past(op_i) inside {3'd1, 3'd2, 3'd3} && !$past(we_i))));

  assert_sfr_route_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_sel_o |-> (addr_i[7] && (op_i == 3'd2 || op_i == 3'd3)));

  assert_sfr_bitable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_bitable_o |-> (sfr_sel_o && sfr_addr_o[2:0] == 3'd0));

  assert_sfr_bitop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_bitop_o |-> (sfr_bitable_o && op_i == 3'd3));

  assert_push_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && !sp_nx[7]) |=> (sp_o == 8'($past(sp_o) + 8'd1) && !stack_err_o));

  assert_pop_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5 && !sp_o[7]) |=> (sp_o == 8'($past(sp_o) - 8'd1) && rvalid_o));

  assert_push_refused_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && sp_nx[7]) |=> (stack_err_o && $stable(sp_o) && !rvalid_o));

  assert_pop_refused_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5 && sp_o[7]) |=> (stack_err_o && $stable(sp_o) && !rvalid_o));

  assert_idle_op_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {3'd0, 3'd6, 3'd7}) |=> (!rvalid_o && !stack_err_o && $stable(sp_o)));
endmodule

bind iram_bank_stack iram_bank_stack_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .we_i(we_i), .addr_i(addr_i),
  .rvalid_o(rvalid_o), .stack_err_o(stack_err_o), .sp_o(sp_o),
  .sfr_sel_o(sfr_sel_o), .sfr_addr_o(sfr_addr_o), .sfr_bitop_o(sfr_bitop_o),
  .sfr_bitable_o(sfr_bitable_o)
);

// File: tb/iram_bank_stack_tb.sv
`timescale 1ns/1ps
module iram_bank_stack_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = '0;
  logic       we = 1'b0;
  logic [1:0] bank = '0;
  logic [2:0] rnum = '0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wbit = 1'b0;
  logic [7:0] rdata, sp, sfr_addr, sfr_wdata;
  logic       rbit, rvalid, stk_err, sfr_sel, sfr_we, sfr_bitop, sfr_wbit, sfr_bitable;
  logic [2:0] sfr_idx;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct packed {
    logic       rd;
    logic       err;
    logic [7:0] data;
    logic       bitv;
    logic [7:0] sp;
    logic [4:0] req;
  } item_t;

  item_t      sb_q[$];
  logic [7:0] ref_mem [128];
  logic [7:0] ref_sp;

  always #10 clk = ~clk;  // 50 MHz

  iram_bank_stack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .we_i(we), .bank_i(bank), .reg_i(rnum),
    .addr_i(addr), .wdata_i(wdata), .wbit_i(wbit), .rdata_o(rdata), .rbit_o(rbit),
    .rvalid_o(rvalid), .sp_o(sp), .stack_err_o(stk_err), .sfr_sel_o(sfr_sel),
    .sfr_we_o(sfr_we), .sfr_addr_o(sfr_addr), .sfr_wdata_o(sfr_wdata),
    .sfr_bitop_o(sfr_bitop), .sfr_bit_idx_o(sfr_idx), .sfr_wbit_o(sfr_wbit),
    .sfr_bitable_o(sfr_bitable)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: applies one operation and queues the expected result
  task automatic drive(input logic [2:0] o, input logic w, input logic [1:0] b, input logic [2:0] r,
                       input logic [7:0] a, input logic [7:0] d, input logic wb, input int req);
    item_t it;
    logic [7:0] t;
    @(negedge clk);
    op = o; we = w; bank = b; rnum = r; addr = a; wdata = d; wbit = wb;
    it = '0;
    it.req = 5'(req);
    case (o)
      3'd1, 3'd2: begin
        t = (o == 3'd1) ? {3'b000, b, r} : a;
        if (!t[7]) begin
          if (w) ref_mem[t[6:0]] = d;
          else begin it.rd = 1'b1; it.data = ref_mem[t[6:0]]; end
        end
      end
      3'd3: if (!a[7]) begin
        t = 8'h20 + (a >> 3);
        if (w) ref_mem[t[6:0]][a[2:0]] = wb;
        else begin it.rd = 1'b1; it.bitv = ref_mem[t[6:0]][a[2:0]]; end
      end
      3'd4: begin
        t = ref_sp + 8'd1;
        if (t[7]) it.err = 1'b1;
        else begin ref_sp = t; ref_mem[t[6:0]] = d; end
      end
      3'd5: begin
        if (ref_sp[7]) it.err = 1'b1;
        else begin it.rd = 1'b1; it.data = ref_mem[ref_sp[6:0]]; ref_sp = ref_sp - 8'd1; end
      end
      default: ;
    endcase
    it.sp = ref_sp;
    sb_q.push_back(it);
  endtask

  task automatic nop(); drive(3'd0, 1'b0, 2'd0, 3'd0, 8'h00, 8'h00, 1'b0, 12); endtask
  task automatic reg_wr(input logic [1:0] b, input logic [2:0] r, input logic [7:0] d); drive(3'd1, 1'b1, b, r, 8'h00, d, 1'b0, 2); endtask
  task automatic reg_rd(input logic [1:0] b, input logic [2:0] r); drive(3'd1, 1'b0, b, r, 8'h00, 8'h00, 1'b0, 2); endtask
  task automatic dir_wr(input logic [7:0] a, input logic [7:0] d, input int req); drive(3'd2, 1'b1, 2'd0, 3'd0, a, d, 1'b0, req); endtask
  task automatic dir_rd(input logic [7:0] a, input int req); drive(3'd2, 1'b0, 2'd0, 3'd0, a, 8'h00, 1'b0, req); endtask
  task automatic bit_wr(input logic [7:0] a, input logic v); drive(3'd3, 1'b1, 2'd0, 3'd0, a, 8'h00, v, 7); endtask
  task automatic bit_rd(input logic [7:0] a); drive(3'd3, 1'b0, 2'd0, 3'd0, a, 8'h00, 1'b0, 6); endtask
  task automatic push(input logic [7:0] d, input int req); drive(3'd4, 1'b0, 2'd0, 3'd0, 8'h00, d, 1'b0, req); endtask
  task automatic pop(input int req); drive(3'd5, 1'b0, 2'd0, 3'd0, 8'h00, 8'h00, 1'b0, req); endtask

  // monitor: compares registered results against the queued expectation
  always @(posedge clk) begin
    item_t it;
    string tg;
    #2;
    if (rst_n) begin
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        tg = $sformatf("R%0d", it.req);
        chk(tg, "rvalid", {7'd0, rvalid}, {7'd0, it.rd});
        chk(tg, "stack_err", {7'd0, stk_err}, {7'd0, it.err});
        chk(tg, "sp", sp, it.sp);
        if (it.rd) begin
          chk(tg, "rdata", rdata, it.data);
          chk(tg, "rbit", {7'd0, rbit}, {7'd0, it.bitv});
        end
      end else if (rvalid || stk_err) begin
        chk("R12", "unexpected strobe", {6'd0, rvalid, stk_err}, 8'h00);
      end
    end
  end

  // SFR port probe, sampled in the cycle of the request (R4, R5, R8)
  task automatic sfr_probe(input logic [2:0] o, input logic w, input logic [7:0] a, input logic [7:0] d,
                           input logic wb, input logic [7:0] ea, input logic ebt, input logic [2:0] eidx);
    drive(o, w, 2'd0, 3'd0, a, d, wb, 4);
    #1;
    chk("R4", "sfr_sel", {7'd0, sfr_sel}, 8'h01);
    chk("R4", "sfr_addr", sfr_addr, ea);
    chk("R4", "sfr_we", {7'd0, sfr_we}, {7'd0, w});
    if (o == 3'd2) chk("R4", "sfr_wdata", sfr_wdata, d);
    chk("R5", "sfr_bitable", {7'd0, sfr_bitable}, {7'd0, ebt});
    chk("R8", "sfr_bitop", {7'd0, sfr_bitop}, {7'd0, (o == 3'd3)});
    if (o == 3'd3) begin
      chk("R8", "sfr_bit_idx", {5'd0, sfr_idx}, {5'd0, eidx});
      chk("R8", "sfr_wbit", {7'd0, sfr_wbit}, {7'd0, wb});
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
    ref_sp = 8'h07;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "sp after reset", sp, 8'h07);
    chk("R1", "rvalid after reset", {7'd0, rvalid}, 8'h00);
    chk("R1", "stack_err after reset", {7'd0, stk_err}, 8'h00);
    chk("R1", "sfr_sel after reset", {7'd0, sfr_sel}, 8'h00);
    dir_rd(8'h45, 1);
    dir_rd(8'h1F, 1);

    // R2: bank windows
    for (int b = 0; b < 4; b++) reg_wr(2'(b), 3'd5, 8'hA0 + 8'(b));
    for (int b = 0; b < 4; b++) dir_rd(8'(b * 8 + 5), 2);
    for (int b = 0; b < 4; b++) reg_rd(2'(b), 3'd5);
    dir_wr(8'h1A, 8'h3C, 2);
    reg_rd(2'd3, 3'd2);

    // R3: direct scratch access
    dir_wr(8'h30, 8'h5A, 3);
    dir_wr(8'h7F, 8'hC3, 3);
    dir_rd(8'h30, 3);
    dir_rd(8'h7F, 3);

    // R4, R5: SFR routing and bit-capable flag
    sfr_probe(3'd2, 1'b1, 8'h90, 8'h6E, 1'b0, 8'h90, 1'b1, 3'd0);
    sfr_probe(3'd2, 1'b0, 8'h81, 8'h00, 1'b0, 8'h81, 1'b0, 3'd0);
    sfr_probe(3'd2, 1'b1, 8'h88, 8'h12, 1'b0, 8'h88, 1'b1, 3'd0);
    sfr_probe(3'd2, 1'b0, 8'hFF, 8'h00, 1'b0, 8'hFF, 1'b0, 3'd0);
    dir_rd(8'h10, 4);  // no alias of 90H into internal memory
    dir_rd(8'h08, 4);

    // R6, R7: bit window
    dir_wr(8'h25, 8'h00, 7);
    bit_wr(8'h2B, 1'b1);       // byte 25H bit 3
    dir_rd(8'h25, 7);          // next clock sees it: 08H
    dir_wr(8'h26, 8'hFF, 7);
    bit_wr(8'h37, 1'b0);       // byte 26H bit 7
    dir_rd(8'h26, 7);          // 7FH
    bit_rd(8'h2B);
    bit_rd(8'h2A);
    bit_wr(8'h00, 1'b1);       // byte 20H bit 0
    bit_rd(8'h00);
    bit_wr(8'h7F, 1'b1);       // byte 2FH bit 7
    dir_rd(8'h2F, 6);

    // R8: bit access in SFR space
    sfr_probe(3'd3, 1'b1, 8'hD5, 8'h00, 1'b1, 8'hD0, 1'b1, 3'd5);
    sfr_probe(3'd3, 1'b0, 8'h8F, 8'h00, 1'b0, 8'h88, 1'b1, 3'd7);
    dir_rd(8'h2F, 8);

    // R9, R10: push and pop ordering
    push(8'h11, 9);
    dir_rd(8'h08, 9);
    reg_rd(2'd1, 3'd0);
    push(8'h22, 9);
    pop(10);
    pop(10);
    nop();

    // R11: fill the stack up to 7FH, then overflow
    for (int i = 0; i < 120; i++) push(8'(i + 1), 9);
    push(8'hEE, 11);
    dir_rd(8'h7F, 11);
    for (int i = 0; i < 128; i++) pop(10);  // ends at pointer FFH
    pop(11);
    push(8'h99, 9);  // wraps to 00H
    dir_rd(8'h00, 9);

    // R12: unused op codes have no effect
    drive(3'd6, 1'b1, 2'd0, 3'd0, 8'h00, 8'hEE, 1'b1, 12);
    drive(3'd7, 1'b1, 2'd0, 3'd0, 8'h30, 8'hEE, 1'b1, 12);
    drive(3'd0, 1'b1, 2'd2, 3'd1, 8'h30, 8'hEE, 1'b1, 12);
    dir_rd(8'h00, 12);
    dir_rd(8'h30, 12);
    reg_rd(2'd2, 3'd1);

    repeat (4) nop();
    @(negedge clk);
    @(negedge clk);
    if (sb_q.size() != 0) chk("R3", "pending results", 8'(sb_q.size()), 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule